// File: doc/BRIEF.md
# Cache Prefetch Request Queue

This block keeps a short, ordered list of hardware prefetch candidates for one cache. Each time the cache takes a demand miss, it presents the miss address and the current time. An external address generator then supplies a few candidate prefetch addresses, one per cycle, each with its own delay. The block screens every candidate against the cache, the miss queue and its own contents. Survivors are appended with a ready time and a memory-side bus request is raised. The cache's fill logic drains the queue through an issue port.

The block also does three kinds of housekeeping on the queue itself. A demand miss cancels a queued prefetch to the same block. An optional serial-squash mode discards recent work from the tail when a new miss arrives. A full queue makes room by discarding its oldest entry. The in-cache filter can be applied when a candidate is inserted or when an entry is issued. Six event counters record what happened to the candidates.

Top module: `pfq_top`

## Requirements
- R1: Every address is reduced to a block address by clearing its low log2(BLK_BYTES) bits. All matching uses block addresses, and the issue port returns block addresses.
- R2: A miss with `miss_uncached` high changes nothing. While `cfg_data_only` is high, a miss with `miss_ifetch` high also changes nothing. While `cfg_data_only` is low, an instruction-fetch miss is handled like any other miss.
- R3: A handled miss whose block equals a queued entry's block removes that entry and adds one to `cnt_miss_removed`. The remaining entries keep their order.
- R4: While `cfg_serial_squash` is high, a handled miss removes entries from the tail for as long as the tail entry's ready time is greater than or equal to `miss_time`. Each removed entry adds one to `cnt_squashed`. An older entry with an earlier ready time stops the walk.
- R5: An accepted candidate gets ready time = time of the last handled miss + `cand_delay`. Candidates enter the queue in the order they are accepted.
- R6: A candidate is dropped in three cases, checked in this order. First, if `cfg_check_on_push` is high and `cand_in_cache` is high. Second, if `cand_in_mshr` is high. Third, if the queue already holds its block; this case adds one to `cnt_buf_hit`. While `cfg_check_on_push` is low, a candidate with `cand_in_cache` high is still inserted.
- R7: Inserting into a full queue (DEPTH entries) first discards the head entry and adds one to `cnt_evicted`. The new entry is then appended at the tail.
- R8: After an insertion, `bus_req` is high and `bus_req_time` carries the ready time of that entry. `bus_req` is low whenever the queue is empty.
- R9: A one-cycle `issue_req` pops the head. The cycle after the pop, `issue_done` pulses with `issue_hit`=1 and the entry's block and ready time, and `cnt_issued` adds one. While `cfg_check_on_push` is low, heads with `head_in_cache` high are popped and skipped, one per cycle. If the queue is or becomes empty, `issue_done` pulses with `issue_hit`=0.
- R10: The queue never holds two entries for the same block.
- R11: Handling is one action per cycle, in this priority order: miss, then issue, then candidate. `cand_ready` is low while `miss_valid` is high or an issue is in progress.
- R12: Every accepted candidate, kept or dropped, adds one to `cnt_identified`.
- R13: After reset, the queue is empty, `bus_req` is low, `cand_ready` is high and all counters are zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cfg_data_only | input | 1 | Ignore instruction-fetch misses |
| cfg_serial_squash | input | 1 | Enable tail squash on a miss |
| cfg_check_on_push | input | 1 | Apply the cache filter at insertion instead of at issue |
| miss_valid | input | 1 | Demand miss present this cycle |
| miss_addr | input | 32 | Miss address |
| miss_time | input | 16 | Current time of the miss |
| miss_uncached | input | 1 | Miss is from an uncacheable request |
| miss_ifetch | input | 1 | Miss is from an instruction fetch |
| cand_valid | input | 1 | Candidate present |
| cand_ready | output | 1 | Candidate accepted this cycle |
| cand_addr | input | 32 | Candidate address |
| cand_delay | input | DLY_W | Candidate delay added to the miss time |
| cand_in_cache | input | 1 | Cache holds the candidate's block |
| cand_in_mshr | input | 1 | Miss queue holds the candidate's block |
| bus_req | output | 1 | Memory-side bus request |
| bus_req_time | output | 16 | Ready time of the latest insertion |
| head_blk | output | 32 | Block address of the head entry, for the cache query |
| head_in_cache | input | 1 | Cache holds `head_blk` |
| issue_req | input | 1 | Request one prefetch |
| issue_done | output | 1 | Issue request finished |
| issue_hit | output | 1 | A prefetch was issued |
| issue_addr | output | 32 | Issued block address |
| issue_time | output | 16 | Issued ready time |
| cnt_identified | output | CNT_W | Candidates accepted |
| cnt_miss_removed | output | CNT_W | Entries removed by a matching miss |
| cnt_squashed | output | CNT_W | Entries removed by serial squash |
| cnt_buf_hit | output | CNT_W | Candidates already queued |
| cnt_evicted | output | CNT_W | Head entries discarded on a full insert |
| cnt_issued | output | CNT_W | Prefetches issued |

## Verification
Some internal faults only reach the ports when the queue is drained, so they surface one cycle after the pop that exposes them. A compaction error after a miss removal shows up as a wrong block or ready time there. A lost tail entry shows up as a premature `issue_hit`=0. A wrong occupancy count shows up at once on `bus_req`, and a wrong full flag shows up in `cnt_evicted` the cycle after the ninth insertion. A mis-screened candidate appears in `cnt_buf_hit` or `cnt_identified` the cycle after it is offered, and later as an extra or missing entry when the queue is drained.

// File: rtl/pfq_pkg.sv
package pfq_pkg;

    localparam int ADDR_W = 32;
    localparam int TIME_W = 16;

    typedef logic [ADDR_W-1:0] addr_t;
    typedef logic [TIME_W-1:0] tick_t;

    // one queued prefetch: aligned block and its ready time
    typedef struct packed {
        addr_t blk;
        tick_t rdy;
    } ent_t;

    // counter slots
    localparam int NUM_EV = 6;
    typedef enum logic [2:0] {
        EV_IDENT   = 3'd0,
        EV_MISS_RM = 3'd1,
        EV_SQUASH  = 3'd2,
        EV_BUF_HIT = 3'd3,
        EV_EVICT   = 3'd4,
        EV_ISSUE   = 3'd5
    } ev_e;

    function automatic addr_t blk_of(input addr_t a, input int off_bits);
        addr_t mask;
        mask = (addr_t'(1) << off_bits) - addr_t'(1);
        return a & ~mask;
    endfunction

endpackage

// File: rtl/pfq_lookup.sv
module pfq_lookup
    import pfq_pkg::*;
#(
    parameter int DEPTH = 8
) (
    input  ent_t [DEPTH-1:0] ents,
    input  logic [DEPTH-1:0] valid,
    input  addr_t            probe,
    output logic [DEPTH-1:0] hit
);
    for (genvar g = 0; g < DEPTH; g++) begin : g_cmp
        assign hit[g] = valid[g] && (ents[g].blk == probe);
    end
endmodule

// File: rtl/pfq_tail_squash.sv
module pfq_tail_squash
    import pfq_pkg::*;
#(
    parameter int DEPTH = 8
) (
    input  ent_t [DEPTH-1:0] ents,
    input  logic [DEPTH-1:0] valid,
    input  tick_t            now,
    output logic [DEPTH-1:0] drop
);
    logic run;

    // walk from the tail toward the head; stop at the first entry older than now
    always_comb begin
        run = 1'b1;
        for (int i = DEPTH - 1; i >= 0; i--) begin
            drop[i] = 1'b0;
            if (valid[i]) begin
                run     = run && (ents[i].rdy >= now);
                drop[i] = run;
            end
        end
    end
endmodule

// File: rtl/pfq_counters.sv
module pfq_counters #(
    parameter int N     = 6,
    parameter int CNT_W = 16,
    parameter int INC_W = 4
) (
    input  logic                      clk,
    input  logic                      rst,
    input  logic [N-1:0][INC_W-1:0]   inc,
    output logic [N-1:0][CNT_W-1:0]   cnt
);
    for (genvar g = 0; g < N; g++) begin : g_ctr
        logic [CNT_W-1:0] val_q;
        always_ff @(posedge clk) begin
            if (rst) val_q <= '0;
            else     val_q <= val_q + CNT_W'(inc[g]);
        end
        assign cnt[g] = val_q;
    end
endmodule

// File: rtl/pfq_top.sv
module pfq_top
    import pfq_pkg::*;
#(
    parameter int DEPTH     = 8,
    parameter int BLK_BYTES = 64,
    parameter int DLY_W     = 8,
    parameter int CNT_W     = 16
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              cfg_data_only,
    input  logic              cfg_serial_squash,
    input  logic              cfg_check_on_push,
    input  logic              miss_valid,
    input  logic [31:0]       miss_addr,
    input  logic [15:0]       miss_time,
    input  logic              miss_uncached,
    input  logic              miss_ifetch,
    input  logic              cand_valid,
    output logic              cand_ready,
    input  logic [31:0]       cand_addr,
    input  logic [DLY_W-1:0]  cand_delay,
    input  logic              cand_in_cache,
    input  logic              cand_in_mshr,
    output logic              bus_req,
    output logic [15:0]       bus_req_time,
    output logic [31:0]       head_blk,
    input  logic              head_in_cache,
    input  logic              issue_req,
    output logic              issue_done,
    output logic              issue_hit,
    output logic [31:0]       issue_addr,
    output logic [15:0]       issue_time,
    output logic [CNT_W-1:0]  cnt_identified,
    output logic [CNT_W-1:0]  cnt_miss_removed,
    output logic [CNT_W-1:0]  cnt_squashed,
    output logic [CNT_W-1:0]  cnt_buf_hit,
    output logic [CNT_W-1:0]  cnt_evicted,
    output logic [CNT_W-1:0]  cnt_issued
);
    localparam int OFF_W = $clog2(BLK_BYTES);
    localparam int CW    = $clog2(DEPTH + 1);

    // state
    ent_t [DEPTH-1:0] ents_q;
    logic [CW-1:0]    cnt_q;
    tick_t            cur_time_q;
    tick_t            bus_time_q;
    logic             pend_q;
    logic             done_q;
    logic             hit_q;
    addr_t            iaddr_q;
    tick_t            itime_q;

    // next state
    ent_t [DEPTH-1:0] n_ents;
    logic [CW-1:0]    n_cnt;
    tick_t            n_time;
    tick_t            n_bus_time;
    logic             n_pend;
    logic             n_done;
    logic             n_hit;
    addr_t            n_iaddr;
    tick_t            n_itime;

    logic [DEPTH-1:0] valid;
    logic [DEPTH-1:0] mhit;
    logic [DEPTH-1:0] chit;
    logic [DEPTH-1:0] sq_drop;
    logic [DEPTH-1:0] sq_eff;
    logic [DEPTH-1:0] keep;
    logic [NUM_EV-1:0][CW-1:0] ev_inc;
    logic [NUM_EV-1:0][CNT_W-1:0] ev_cnt;

    addr_t miss_blk;
    addr_t cand_blk;
    tick_t cand_time;
    ent_t  new_ent;
    logic  miss_take;
    logic  issue_act;
    logic  cand_fire;
    logic  drop_cache;
    logic  drop_mshr;
    logic  drop_buf;
    logic  ins;
    logic  full;
    logic  head_skip;
    int    k;

    always_comb begin
        for (int i = 0; i < DEPTH; i++) valid[i] = (CW'(i) < cnt_q);
    end

    assign miss_blk  = blk_of(miss_addr, OFF_W);
    assign cand_blk  = blk_of(cand_addr, OFF_W);
    assign cand_time = cur_time_q + TIME_W'(cand_delay);
    assign miss_take = miss_valid && !miss_uncached && !(cfg_data_only && miss_ifetch);
    assign issue_act = (issue_req || pend_q) && !miss_valid;
    assign cand_ready = !miss_valid && !issue_act;
    assign cand_fire = cand_valid && cand_ready;
    assign full      = (cnt_q == CW'(DEPTH));

    assign drop_cache = cfg_check_on_push && cand_in_cache;
    assign drop_mshr  = !drop_cache && cand_in_mshr;
    assign drop_buf   = !drop_cache && !drop_mshr && (|chit);
    assign ins        = cand_fire && !drop_cache && !drop_mshr && !drop_buf;

    assign head_skip  = !cfg_check_on_push && head_in_cache;
    assign sq_eff     = cfg_serial_squash ? sq_drop : '0;
    assign keep       = valid & ~mhit & ~sq_eff;

    pfq_lookup #(.DEPTH(DEPTH)) miss_lk_i (
        .ents(ents_q), .valid(valid), .probe(miss_blk), .hit(mhit)
    );

    pfq_lookup #(.DEPTH(DEPTH)) cand_lk_i (
        .ents(ents_q), .valid(valid), .probe(cand_blk), .hit(chit)
    );

    pfq_tail_squash #(.DEPTH(DEPTH)) squash_i (
        .ents(ents_q), .valid(valid & ~mhit), .now(miss_time), .drop(sq_drop)
    );

    always_comb begin
        n_ents     = ents_q;
        n_cnt      = cnt_q;
        n_time     = cur_time_q;
        n_bus_time = bus_time_q;
        n_pend     = pend_q;
        n_done     = 1'b0;
        n_hit      = 1'b0;
        n_iaddr    = iaddr_q;
        n_itime    = itime_q;
        ev_inc     = '0;
        new_ent.blk = cand_blk;
        new_ent.rdy = cand_time;
        k = 0;
        if (miss_valid) begin
            if (miss_take) begin
                n_time = miss_time;
                for (int i = 0; i < DEPTH; i++) begin
                    if (keep[i]) begin
                        n_ents[k] = ents_q[i];
                        k = k + 1;
                    end
                end
                n_cnt = CW'(k);
                ev_inc[EV_MISS_RM] = CW'(|mhit);
                ev_inc[EV_SQUASH]  = CW'($countones(sq_eff));
            end
        end else if (issue_act) begin
            if (cnt_q == '0) begin
                n_pend = 1'b0;
                n_done = 1'b1;
            end else begin
                for (int i = 0; i < DEPTH - 1; i++) n_ents[i] = ents_q[i+1];
                n_cnt = cnt_q - CW'(1);
                if (head_skip) begin
                    n_pend = (cnt_q != CW'(1));
                    n_done = (cnt_q == CW'(1));
                end else begin
                    n_pend  = 1'b0;
                    n_done  = 1'b1;
                    n_hit   = 1'b1;
                    n_iaddr = ents_q[0].blk;
                    n_itime = ents_q[0].rdy;
                    ev_inc[EV_ISSUE] = CW'(1);
                end
            end
        end else if (cand_fire) begin
            ev_inc[EV_IDENT]   = CW'(1);
            ev_inc[EV_BUF_HIT] = CW'(drop_buf);
            if (ins) begin
                n_bus_time = cand_time;
                if (full) begin
                    for (int i = 0; i < DEPTH - 1; i++) n_ents[i] = ents_q[i+1];
                    n_ents[DEPTH-1] = new_ent;
                    ev_inc[EV_EVICT] = CW'(1);
                end else begin
                    for (int i = 0; i < DEPTH; i++) begin
                        if (CW'(i) == cnt_q) n_ents[i] = new_ent;
                    end
                    n_cnt = cnt_q + CW'(1);
                end
            end
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            ents_q     <= '0;
            cnt_q      <= '0;
            cur_time_q <= '0;
            bus_time_q <= '0;
            pend_q     <= 1'b0;
            done_q     <= 1'b0;
            hit_q      <= 1'b0;
            iaddr_q    <= '0;
            itime_q    <= '0;
        end else begin
            ents_q     <= n_ents;
            cnt_q      <= n_cnt;
            cur_time_q <= n_time;
            bus_time_q <= n_bus_time;
            pend_q     <= n_pend;
            done_q     <= n_done;
            hit_q      <= n_hit;
            iaddr_q    <= n_iaddr;
            itime_q    <= n_itime;
        end
    end

    pfq_counters #(.N(NUM_EV), .CNT_W(CNT_W), .INC_W(CW)) ctr_i (
        .clk(clk), .rst(rst), .inc(ev_inc), .cnt(ev_cnt)
    );

    assign bus_req          = (cnt_q != '0);
    assign bus_req_time     = bus_time_q;
    assign head_blk         = ents_q[0].blk;
    assign issue_done       = done_q;
    assign issue_hit        = hit_q;
    assign issue_addr       = iaddr_q;
    assign issue_time       = itime_q;
    assign cnt_identified   = ev_cnt[EV_IDENT];
    assign cnt_miss_removed = ev_cnt[EV_MISS_RM];
    assign cnt_squashed     = ev_cnt[EV_SQUASH];
    assign cnt_buf_hit      = ev_cnt[EV_BUF_HIT];
    assign cnt_evicted      = ev_cnt[EV_EVICT];
    assign cnt_issued       = ev_cnt[EV_ISSUE];

endmodule

// File: rtl/pfq_top_chk.sv
module pfq_top_chk #(
    parameter int DEPTH = 8,
    parameter int CW    = 4
) (
    input logic             clk,
    input logic             rst,
    input logic [CW-1:0]    cnt_q,
    input logic             miss_valid,
    input logic             miss_take,
    input logic             ins,
    input logic             full,
    input logic [15:0]      cand_time,
    input logic             bus_req,
    input logic [15:0]      bus_req_time,
    input logic             issue_done,
    input logic             issue_hit,
    input logic [DEPTH-1:0] mhit,
    input logic [DEPTH-1:0] chit,
    input logic             cand_ready
);
    // R13: occupancy never exceeds capacity
    a_r13_cnt_bound: assert property (@(posedge clk) disable iff (rst)
        cnt_q <= CW'(DEPTH));

    // R2: an ignored miss leaves the queue untouched
    a_r2_ignored_miss: assert property (@(posedge clk) disable iff (rst)
        (miss_valid && !miss_take) |=> (cnt_q == $past(cnt_q)));

    // R7: an insert into a full queue leaves it full
    a_r7_evict_stays_full: assert property (@(posedge clk) disable iff (rst)
        (ins && full) |=> (cnt_q == CW'(DEPTH)));

    // R8: every insertion raises the bus request with its ready time
    a_r8_bus_on_insert: assert property (@(posedge clk) disable iff (rst)
        ins |=> (bus_req && bus_req_time == $past(cand_time)));

    // R9: a successful issue shrinks the queue
    a_r9_issue_pops: assert property (@(posedge clk) disable iff (rst)
        (issue_done && issue_hit) |-> (cnt_q < $past(cnt_q)));

    // R10: at most one queued entry per block
    a_r10_unique_miss: assert property (@(posedge clk) disable iff (rst)
        $onehot0(mhit));
    a_r10_unique_cand: assert property (@(posedge clk) disable iff (rst)
        $onehot0(chit));

    // R11: a miss blocks candidate acceptance
    a_r11_miss_priority: assert property (@(posedge clk) disable iff (rst)
        miss_valid |-> !cand_ready);
endmodule

bind pfq_top pfq_top_chk #(.DEPTH(DEPTH), .CW(CW)) chk_i (
    .clk(clk), .rst(rst), .cnt_q(cnt_q), .miss_valid(miss_valid),
    .miss_take(miss_take), .ins(ins), .full(full), .cand_time(cand_time),
    .bus_req(bus_req), .bus_req_time(bus_req_time), .issue_done(issue_done),
    .issue_hit(issue_hit), .mhit(mhit), .chit(chit), .cand_ready(cand_ready)
);

// File: tb/pfq_top_tb_top.sv
module pfq_top_tb_top;
    localparam int CNT_W = 16;
    localparam int DLY_W = 8;

    logic clk = 1'b0;
    logic rst = 1'b1;
    always #5 clk = ~clk;

    logic cfg_data_only = 0, cfg_serial_squash = 0, cfg_check_on_push = 1;
    logic miss_valid = 0, miss_uncached = 0, miss_ifetch = 0;
    logic [31:0] miss_addr = '0;
    logic [15:0] miss_time = '0;
    logic cand_valid = 0, cand_in_cache = 0, cand_in_mshr = 0;
    logic cand_ready;
    logic [31:0] cand_addr = '0;
    logic [DLY_W-1:0] cand_delay = '0;
    logic bus_req;
    logic [15:0] bus_req_time;
    logic [31:0] head_blk;
    logic head_in_cache;
    logic issue_req = 0;
    logic issue_done, issue_hit;
    logic [31:0] issue_addr;
    logic [15:0] issue_time;
    logic [CNT_W-1:0] c_ident, c_mrm, c_sq, c_buf, c_evict, c_issued;

    logic [31:0] cset [4];
    logic [3:0]  cset_v = '0;

    always_comb begin
        head_in_cache = 1'b0;
        for (int i = 0; i < 4; i++)
            if (cset_v[i] && cset[i] == head_blk) head_in_cache = 1'b1;
    end

    pfq_top #(.DEPTH(8), .BLK_BYTES(64), .DLY_W(DLY_W), .CNT_W(CNT_W)) dut_i (
        .clk(clk), .rst(rst),
        .cfg_data_only(cfg_data_only), .cfg_serial_squash(cfg_serial_squash),
        .cfg_check_on_push(cfg_check_on_push),
        .miss_valid(miss_valid), .miss_addr(miss_addr), .miss_time(miss_time),
        .miss_uncached(miss_uncached), .miss_ifetch(miss_ifetch),
        .cand_valid(cand_valid), .cand_ready(cand_ready), .cand_addr(cand_addr),
        .cand_delay(cand_delay), .cand_in_cache(cand_in_cache), .cand_in_mshr(cand_in_mshr),
        .bus_req(bus_req), .bus_req_time(bus_req_time),
        .head_blk(head_blk), .head_in_cache(head_in_cache),
        .issue_req(issue_req), .issue_done(issue_done), .issue_hit(issue_hit),
        .issue_addr(issue_addr), .issue_time(issue_time),
        .cnt_identified(c_ident), .cnt_miss_removed(c_mrm), .cnt_squashed(c_sq),
        .cnt_buf_hit(c_buf), .cnt_evicted(c_evict), .cnt_issued(c_issued)
    );

    int n_chk = 0;
    int n_fail = 0;
    bit finished = 0;

    // expected counters
    int e_ident = 0, e_mrm = 0, e_sq = 0, e_buf = 0, e_evict = 0, e_issued = 0;

    typedef struct packed {
        logic [31:0] addr;
        logic [7:0]  dly;
        logic        in_c;
        logic        in_m;
        logic [15:0] bus_t;
        logic [15:0] buf_n;
    } vec_t;

    // miss at time 100, insertion-time cache filter on
    localparam vec_t VEC [6] = '{
        '{32'h0000_2004, 8'd5, 1'b0, 1'b0, 16'd105, 16'd0},
        '{32'h0000_3000, 8'd7, 1'b1, 1'b0, 16'd105, 16'd0},
        '{32'h0000_4010, 8'd3, 1'b0, 1'b1, 16'd105, 16'd0},
        '{32'h0000_2030, 8'd9, 1'b0, 1'b0, 16'd105, 16'd1},
        '{32'h0000_5000, 8'd2, 1'b0, 1'b0, 16'd102, 16'd1},
        '{32'h0000_6040, 8'd4, 1'b0, 1'b0, 16'd104, 16'd1}
    };

    task automatic check(input string req, input string what,
                         input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
        end
    endtask

    task automatic check_ctrs(input string req);
        check(req, "cnt_identified",   32'(c_ident),  32'(e_ident));
        check(req, "cnt_miss_removed", 32'(c_mrm),    32'(e_mrm));
        check(req, "cnt_squashed",     32'(c_sq),     32'(e_sq));
        check(req, "cnt_buf_hit",      32'(c_buf),    32'(e_buf));
        check(req, "cnt_evicted",      32'(c_evict),  32'(e_evict));
        check(req, "cnt_issued",       32'(c_issued), 32'(e_issued));
    endtask

    task automatic do_miss(input logic [31:0] a, input logic [15:0] t,
                           input logic unc, input logic ifc);
        @(negedge clk);
        miss_valid = 1; miss_addr = a; miss_time = t;
        miss_uncached = unc; miss_ifetch = ifc;
        @(negedge clk);
        miss_valid = 0; miss_uncached = 0; miss_ifetch = 0;
    endtask

    task automatic do_cand(input logic [31:0] a, input logic [7:0] d,
                           input logic c, input logic m);
        @(negedge clk);
        cand_valid = 1; cand_addr = a; cand_delay = d;
        cand_in_cache = c; cand_in_mshr = m;
        @(negedge clk);
        cand_valid = 0; cand_in_cache = 0; cand_in_mshr = 0;
        e_ident++;
    endtask

    task automatic expect_issue(input string req, input logic hit,
                                input logic [31:0] a, input logic [15:0] t);
        int guard;
        @(negedge clk);
        issue_req = 1;
        @(negedge clk);
        issue_req = 0;
        guard = 0;
        while (!issue_done && guard < 20) begin
            @(negedge clk);
            guard++;
        end
        check(req, "issue_done", 32'(issue_done), 32'd1);
        check(req, "issue_hit", 32'(issue_hit), 32'(hit));
        if (hit) begin
            e_issued++;
            check(req, "issue_addr", issue_addr, a);
            check(req, "issue_time", 32'(issue_time), 32'(t));
        end
    endtask

    initial begin
        repeat (50000) @(posedge clk);
        if (!finished) begin
            n_fail++;
            n_chk++;
            $display("FAIL watchdog: actual hung expected completion");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_fail);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        rst = 0;
        @(negedge clk);
        // R13: reset state
        check("R13", "bus_req", 32'(bus_req), 32'd0);
        check("R13", "cand_ready", 32'(cand_ready), 32'd1);
        check_ctrs("R13");

        // R6 R5 R1 R12: table of candidates after a miss at time 100
        do_miss(32'h0000_1000, 16'd100, 0, 0);
        for (int i = 0; i < 6; i++) begin
            do_cand(VEC[i].addr, VEC[i].dly, VEC[i].in_c, VEC[i].in_m);
            check("R8", "bus_req_time", 32'(bus_req_time), 32'(VEC[i].bus_t));
            check("R6", "cnt_buf_hit", 32'(c_buf), 32'(VEC[i].buf_n));
            check("R12", "cnt_identified", 32'(c_ident), 32'(i + 1));
        end
        e_buf = 1;
        check("R8", "bus_req", 32'(bus_req), 32'd1);

        // R3 R1: miss inside block 0x5000 removes that entry
        do_miss(32'h0000_5008, 16'd200, 0, 0);
        e_mrm++;
        check_ctrs("R3");

        // R2: ignored misses to 0x2000 block
        do_miss(32'h0000_2000, 16'd300, 1, 0);
        cfg_data_only = 1;
        do_miss(32'h0000_2000, 16'd300, 0, 1);
        check_ctrs("R2");
        cfg_data_only = 0;
        do_miss(32'h0000_6040, 16'd300, 0, 1);
        e_mrm++;
        check("R2", "cnt_miss_removed", 32'(c_mrm), 32'(e_mrm));

        // R9 R3 R5: drain; only 0x2000 left with ready 105
        expect_issue("R9", 1, 32'h0000_2000, 16'd105);
        check("R8", "bus_req empty", 32'(bus_req), 32'd0);
        expect_issue("R9", 0, 32'h0, 16'h0);
        check_ctrs("R9");

        // R4: serial squash
        cfg_serial_squash = 1;
        cfg_check_on_push = 0;
        do_miss(32'h0000_0100, 16'd10, 0, 0);
        do_cand(32'h0000_A000, 8'd0, 0, 0);
        do_cand(32'h0000_B000, 8'd20, 0, 0);
        do_cand(32'h0000_C000, 8'd5, 0, 0);
        do_miss(32'h0000_0200, 16'd20, 0, 0);
        check("R4", "cnt_squashed tail older", 32'(c_sq), 32'd0);
        do_miss(32'h0000_0300, 16'd12, 0, 0);
        e_sq = 2;
        check_ctrs("R4");
        expect_issue("R4", 1, 32'h0000_A000, 16'd10);
        expect_issue("R4", 0, 32'h0, 16'h0);

        // R7: nine inserts into an eight-entry queue
        cfg_serial_squash = 0;
        cfg_check_on_push = 1;
        do_miss(32'h0000_0400, 16'd1000, 0, 0);
        for (int i = 0; i < 9; i++)
            do_cand(32'h0001_0000 + 32'(i) * 32'h40, 8'(i), 0, 0);
        e_evict = 1;
        check_ctrs("R7");
        for (int i = 1; i < 9; i++)
            expect_issue("R7", 1, 32'h0001_0000 + 32'(i) * 32'h40, 16'(1000 + i));
        check("R8", "bus_req drained", 32'(bus_req), 32'd0);

        // R9 R6: issue-time cache filter
        cfg_check_on_push = 0;
        do_miss(32'h0000_0500, 16'd50, 0, 0);
        do_cand(32'h0002_0000, 8'd1, 1, 0);
        do_cand(32'h0002_0040, 8'd2, 0, 0);
        do_cand(32'h0002_0080, 8'd3, 0, 0);
        cset[0] = 32'h0002_0000; cset[1] = 32'h0002_0040;
        cset_v = 4'b0011;
        expect_issue("R9", 1, 32'h0002_0080, 16'd53);
        do_cand(32'h0002_0000, 8'd4, 0, 0);
        check("R8", "bus_req refill", 32'(bus_req), 32'd1);
        expect_issue("R9", 0, 32'h0, 16'h0);
        check("R9", "bus_req after skip", 32'(bus_req), 32'd0);
        cset_v = '0;

        // R11: a miss blocks candidates
        @(negedge clk);
        miss_valid = 1; miss_uncached = 1; miss_addr = 32'h0;
        cand_valid = 1; cand_addr = 32'h0003_0000; cand_delay = 8'd1;
        #1;
        check("R11", "cand_ready", 32'(cand_ready), 32'd0);
        @(negedge clk);
        miss_valid = 0; miss_uncached = 0; cand_valid = 0;
        check_ctrs("R11");

        finished = 1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_fail);
        $finish;
    end
endmodule